// File: doc/BRIEF.md
# Page Hamming ECC engine

This block keeps a single-error-correcting, double-error-detecting Hamming code over the whole main area of a NAND page while the page words stream past on an 8-bit or 16-bit data bus. Every accepted data word is folded into two 16-bit accumulators. The first accumulator is the parity over the bit positions whose address bit is one. The second is the complementary parity over the positions whose address bit is zero. The position address of a data bit is its word index followed by its bit index within the word.

When a page is written, firmware streams the page and then copies both accumulators into the spare area as four ECC bytes. When a page is read, the four stored ECC bytes are streamed straight after the page data. The block then compares them with its own accumulators and reports one of four outcomes:

- the data is clean;
- a single data bit is wrong, and the block gives its word and bit location;
- a bit of the stored code itself is wrong;
- the page holds an uncorrectable pattern, which is also the signature of an erased page.

A clear command resets the block between pages. It also discards any strobes that were counted by mistake before the data starts.

Top module: `ecc_page_hamming`

## Requirements
- R1: After the asynchronous reset, `par_lo_o` and `par_hi_o` are 0, and `err_any_o`, `err_ecc_o`, `err_multi_o` and `check_done_o` are all 0.
- R2: The protected main area holds 512 << `mode_i` bytes. Modes 0..3 give 512, 1024, 2048 and 4096 bytes, for pages of 528, 1056, 2112 and 4224 bytes. It is taken as that many words on the 8-bit bus and half as many on the 16-bit bus (`bus16_i`=1). The first that many strobes after a clear are data words, with word addresses 0, 1, 2 and so on. A cycle with `stb_i` low changes nothing.
- R3: A data bit at word w and bit b has the position address {w[11:0], b[3:0]}. Bit k of P is the XOR of the data bits whose position address has bit k set. Bit k of P' is the XOR of the data bits whose position address has bit k clear. On the 8-bit bus only `din_i[7:0]` is used. While `check_done_o` is 0, `par_lo_o` shows P and `par_hi_o` shows P'.
- R4: After the data words come the four ECC bytes, in the order P[7:0], P[15:8], P'[7:0], P'[15:8]. On the 8-bit bus they arrive as four strobes on `din_i[7:0]`. On the 16-bit bus they arrive as two strobes, the stored P word and then the stored P' word. `check_done_o` and the flags update at the clock edge that samples the final ECC strobe, and not earlier.
- R5: If the stored code matches the code computed from the data, all three error flags are 0 and `par_lo_o` reads 0.
- R6: A single flipped data bit gives `err_any_o`=1, `err_ecc_o`=0 and `err_multi_o`=0. `par_lo_o` then holds the bit offset in [3:0] and the word address in [15:4]. The bit offset counts within a 16-bit word on the 16-bit bus and within a byte on the 8-bit bus.
- R7: A single flipped bit inside the stored ECC bytes gives `err_any_o`=1, `err_ecc_o`=1 and `err_multi_o`=0, with `par_lo_o` reading 0.
- R8: Any other mismatch gives `err_any_o`=1, `err_multi_o`=1 and `err_ecc_o`=0, with `par_lo_o` reading 16'hFFFF. This covers two flipped data bits, and it covers an erased page in which the data and all four ECC bytes are all ones.
- R9: A cycle with `clr_i` high returns both accumulators, the counters and the results to the reset state at that clock edge. `clr_i` takes priority over a strobe in the same cycle.
- R10: Once `check_done_o` is 1, further strobes change no output until the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear command: restart accumulation for a new page |
| stb_i | input | 1 | Data strobe: `din_i` carries a word this cycle |
| din_i | input | 16 | Data or ECC word; only [7:0] is used on the 8-bit bus |
| mode_i | input | 2 | Page-size mode, 0..3; held steady between clears |
| bus16_i | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus; held steady between clears |
| par_lo_o | output | 16 | P while accumulating; the error location once the check is done |
| par_hi_o | output | 16 | Complementary parity P' |
| err_any_o | output | 1 | Some mismatch was found |
| err_ecc_o | output | 1 | The mismatch lies in the stored ECC bytes |
| err_multi_o | output | 1 | Uncorrectable mismatch, or an erased page |
| check_done_o | output | 1 | The check of the stored code has completed |

## Verification
Pages of random data are run in every page-size mode on both bus widths. Each page takes one of five treatments: intact, one flipped data bit, one flipped code bit, two flipped data bits, or an erased page of all ones. The five treatments must yield five separate flag and location patterns. The random single-bit positions test whether the word and bit fields are packed and scaled correctly for each bus width, while junk on the unused upper byte of the 8-bit bus tests that those lines are ignored. Random idle cycles between strobes, junk strobes followed by a clear, and strobes sent after the check separate correct word counting from counting that drifts or keeps going.

// File: rtl/ecc_pg_pkg.sv
package ecc_pg_pkg;

    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_ECC  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        V_CLEAN  = 2'd0,
        V_SINGLE = 2'd1,
        V_CODE   = 2'd2,
        V_MULTI  = 2'd3
    } verdict_e;

endpackage

// File: rtl/ecc_pg_seq.sv
module ecc_pg_seq #(
    parameter int unsigned WAW       = 12,
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned BASE_LOG  = 9,
    parameter int unsigned ECC_BYTES = 4,
    parameter int unsigned EIDX_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 stb_i,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic                 bus16_i,
    output logic                 data_take_o,
    output logic [WAW-1:0]       waddr_o,
    output logic                 ecc_take_o,
    output logic [EIDX_W-1:0]    eidx_o,
    output logic                 ecc_last_o,
    output ecc_pg_pkg::phase_e   phase_o
);
    import ecc_pg_pkg::*;

    localparam int unsigned CW = WAW + 1;

    typedef struct packed {
        phase_e              ph;
        logic [WAW-1:0]      cnt;
        logic [EIDX_W-1:0]   eidx;
    } seq_t;

    seq_t s_d, s_q;

    logic [CW-1:0]     nwords;
    logic [CW-1:0]     word_last;
    logic [EIDX_W-1:0] ecc_idx_last;
    logic              at_word_last;
    logic              at_ecc_last;

    // Main-area length in bus words for the selected mode and bus width.
    assign nwords       = (CW'(1) << (BASE_LOG + 32'(mode_i))) >> bus16_i;
    assign word_last    = nwords - CW'(1);
    assign ecc_idx_last = bus16_i ? EIDX_W'(ECC_BYTES / 2 - 1) : EIDX_W'(ECC_BYTES - 1);
    assign at_word_last = ({1'b0, s_q.cnt} == word_last);
    assign at_ecc_last  = (s_q.eidx == ecc_idx_last);

    always_comb begin
        s_d         = s_q;
        data_take_o = 1'b0;
        ecc_take_o  = 1'b0;
        ecc_last_o  = 1'b0;
        if (clr_i) begin
            s_d.ph   = PH_DATA;
            s_d.cnt  = '0;
            s_d.eidx = '0;
        end else if (stb_i) begin
            case (s_q.ph)
                PH_DATA: begin
                    data_take_o = 1'b1;
                    if (at_word_last) begin
                        s_d.ph  = PH_ECC;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + WAW'(1);
                    end
                end
                PH_ECC: begin
                    ecc_take_o = 1'b1;
                    if (at_ecc_last) begin
                        ecc_last_o = 1'b1;
                        s_d.ph     = PH_DONE;
                    end else begin
                        s_d.eidx = s_q.eidx + EIDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph   <= PH_DATA;
            s_q.cnt  <= '0;
            s_q.eidx <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign waddr_o = s_q.cnt;
    assign eidx_o  = s_q.eidx;
    assign phase_o = s_q.ph;

endmodule

// File: rtl/ecc_pg_accum.sv
module ecc_pg_accum #(
    parameter int unsigned DW        = 16,
    parameter int unsigned BAW       = 4,
    parameter int unsigned WAW       = 12,
    parameter int unsigned ECC_BYTES = 4,
    parameter int unsigned EIDX_W    = 2,
    parameter int unsigned PW        = BAW + WAW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 data_take_i,
    input  logic [WAW-1:0]       waddr_i,
    input  logic [DW-1:0]        din_i,
    input  logic                 bus16_i,
    input  logic                 ecc_take_i,
    input  logic [EIDX_W-1:0]    eidx_i,
    output logic [PW-1:0]        p_o,
    output logic [PW-1:0]        pc_o,
    output logic [2*PW-1:0]      code_next_o
);
    localparam int unsigned HALF = DW / 2;

    typedef struct packed {
        logic [PW-1:0]   p;
        logic [PW-1:0]   pc;
        logic [2*PW-1:0] code;
    } acc_t;

    acc_t a_d, a_q;

    logic [DW-1:0]  dm;
    logic           tot;
    logic [BAW-1:0] bhi, blo;
    logic [WAW-1:0] whi, wlo;

    // Lanes whose bit index has bit k set.
    function automatic logic [DW-1:0] lane_mask(input int k);
        logic [DW-1:0] m;
        for (int b = 0; b < DW; b++) begin
            m[b] = ((b >> k) & 1) == 1;
        end
        return m;
    endfunction

    assign dm  = bus16_i ? din_i : {{HALF{1'b0}}, din_i[HALF-1:0]};
    assign tot = ^dm;

    generate
        for (genvar gk = 0; gk < BAW; gk++) begin : g_bitaddr
            localparam logic [DW-1:0] MSK = lane_mask(gk);
            assign bhi[gk] = ^(dm & MSK);
            assign blo[gk] = ^(dm & ~MSK);
        end
    endgenerate

    // Word-address bits: the whole word parity goes to one side per bit.
    assign whi = waddr_i & {WAW{tot}};
    assign wlo = ~waddr_i & {WAW{tot}};

    always_comb begin
        a_d = a_q;
        if (clr_i) begin
            a_d = '0;
        end else begin
            if (data_take_i) begin
                a_d.p  = a_q.p ^ {whi, bhi};
                a_d.pc = a_q.pc ^ {wlo, blo};
            end
            if (ecc_take_i) begin
                for (int i = 0; i < int'(ECC_BYTES); i++) begin
                    if (!bus16_i && (int'(eidx_i) == i)) begin
                        a_d.code[HALF*i +: HALF] = din_i[HALF-1:0];
                    end
                    if (bus16_i && (int'(eidx_i) == i / 2)) begin
                        a_d.code[HALF*i +: HALF] = din_i[HALF*(i%2) +: HALF];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign p_o         = a_q.p;
    assign pc_o        = a_q.pc;
    assign code_next_o = a_d.code;

endmodule

// File: rtl/ecc_pg_decode.sv
module ecc_pg_decode #(
    parameter int unsigned PW = 16
) (
    input  logic [PW-1:0]          p_i,
    input  logic [PW-1:0]          pc_i,
    input  logic [2*PW-1:0]        code_i,
    output ecc_pg_pkg::verdict_e   verdict_o,
    output logic [PW-1:0]          loc_o
);
    import ecc_pg_pkg::*;

    logic [PW-1:0] syn, sync;
    logic          nonzero, one_bit, mirrored;

    assign syn      = p_i ^ code_i[PW-1:0];
    assign sync     = pc_i ^ code_i[2*PW-1:PW];
    assign nonzero  = |{syn, sync};
    assign one_bit  = $onehot({syn, sync});
    assign mirrored = &(syn ^ sync);

    always_comb begin
        verdict_o = V_CLEAN;
        loc_o     = '0;
        if (nonzero) begin
            if (one_bit) begin
                verdict_o = V_CODE;
            end else if (mirrored) begin
                verdict_o = V_SINGLE;
                loc_o     = syn;
            end else begin
                verdict_o = V_MULTI;
                loc_o     = '1;
            end
        end
    end

endmodule

// File: rtl/ecc_page_hamming.sv
module ecc_page_hamming #(
    parameter int unsigned DW        = 16,
    parameter int unsigned BAW       = 4,
    parameter int unsigned WAW       = 12,
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned BASE_LOG  = 9,
    parameter int unsigned ECC_BYTES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       stb_i,
    input  logic [DW-1:0]              din_i,
    input  logic [MODE_W-1:0]          mode_i,
    input  logic                       bus16_i,
    output logic [BAW+WAW-1:0]         par_lo_o,
    output logic [BAW+WAW-1:0]         par_hi_o,
    output logic                       err_any_o,
    output logic                       err_ecc_o,
    output logic                       err_multi_o,
    output logic                       check_done_o
);
    import ecc_pg_pkg::*;

    localparam int unsigned PW     = BAW + WAW;
    localparam int unsigned EIDX_W = (ECC_BYTES > 1) ? $clog2(ECC_BYTES) : 1;

    typedef struct packed {
        logic          done;
        logic          any;
        logic          code;
        logic          multi;
        logic [PW-1:0] loc;
    } res_t;

    res_t r_d, r_q;

    logic              data_take, ecc_take, ecc_last;
    logic [WAW-1:0]    waddr;
    logic [EIDX_W-1:0] eidx;
    phase_e            phase;
    logic [PW-1:0]     p, pc, loc;
    logic [2*PW-1:0]   code_next;
    verdict_e          verdict;

    ecc_pg_seq #(
        .WAW(WAW), .MODE_W(MODE_W), .BASE_LOG(BASE_LOG),
        .ECC_BYTES(ECC_BYTES), .EIDX_W(EIDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .stb_i(stb_i),
        .mode_i(mode_i), .bus16_i(bus16_i),
        .data_take_o(data_take), .waddr_o(waddr),
        .ecc_take_o(ecc_take), .eidx_o(eidx), .ecc_last_o(ecc_last),
        .phase_o(phase)
    );

    ecc_pg_accum #(
        .DW(DW), .BAW(BAW), .WAW(WAW), .ECC_BYTES(ECC_BYTES),
        .EIDX_W(EIDX_W), .PW(PW)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .data_take_i(data_take), .waddr_i(waddr), .din_i(din_i),
        .bus16_i(bus16_i), .ecc_take_i(ecc_take), .eidx_i(eidx),
        .p_o(p), .pc_o(pc), .code_next_o(code_next)
    );

    ecc_pg_decode #(.PW(PW)) u_dec (
        .p_i(p), .pc_i(pc), .code_i(code_next),
        .verdict_o(verdict), .loc_o(loc)
    );

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d = '0;
        end else if (ecc_last && (phase == PH_ECC)) begin
            r_d.done  = 1'b1;
            r_d.any   = (verdict != V_CLEAN);
            r_d.code  = (verdict == V_CODE);
            r_d.multi = (verdict == V_MULTI);
            r_d.loc   = loc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign par_lo_o     = r_q.done ? r_q.loc : p;
    assign par_hi_o     = pc;
    assign err_any_o    = r_q.any;
    assign err_ecc_o    = r_q.code;
    assign err_multi_o  = r_q.multi;
    assign check_done_o = r_q.done;

endmodule

// File: rtl/ecc_page_hamming_chk.sv
module ecc_page_hamming_chk #(
    parameter int unsigned PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_i,
    input logic          stb_i,
    input logic [PW-1:0] par_lo_o,
    input logic [PW-1:0] par_hi_o,
    input logic          err_any_o,
    input logic          err_ecc_o,
    input logic          err_multi_o,
    input logic          check_done_o
);

    AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(check_done_o) |-> $past(stb_i) && !$past(clr_i)); // R4

    AST_NO_FLAG_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !check_done_o |-> !err_any_o && !err_ecc_o && !err_multi_o); // R4

    AST_CODE_ERR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        err_ecc_o |-> err_any_o && !err_multi_o && (par_lo_o == '0)); // R7

    AST_MULTI_LOC: assert property (@(posedge clk) disable iff (!rst_n)
        err_multi_o |-> err_any_o && !err_ecc_o && (par_lo_o == '1)); // R8

    AST_CLEAN_LOC: assert property (@(posedge clk) disable iff (!rst_n)
        (check_done_o && !err_any_o) |-> (par_lo_o == '0)); // R5

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !check_done_o && !err_any_o && (par_lo_o == '0) && (par_hi_o == '0)); // R9

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (check_done_o && !clr_i) |=> check_done_o && $stable(par_lo_o) && $stable(par_hi_o)
            && $stable(err_any_o) && $stable(err_ecc_o) && $stable(err_multi_o)); // R10

endmodule

bind ecc_page_hamming ecc_page_hamming_chk #(.PW(BAW + WAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .stb_i(stb_i),
    .par_lo_o(par_lo_o), .par_hi_o(par_hi_o),
    .err_any_o(err_any_o), .err_ecc_o(err_ecc_o), .err_multi_o(err_multi_o),
    .check_done_o(check_done_o)
);

// File: tb/ecc_page_hamming_bench.sv
module ecc_page_hamming_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        stb_i = 1'b0;
    logic [15:0] din_i = '0;
    logic [1:0]  mode_i = '0;
    logic        bus16_i = 1'b0;
    logic [15:0] par_lo_o, par_hi_o;
    logic        err_any_o, err_ecc_o, err_multi_o, check_done_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] pg [0:4095];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ecc_page_hamming u_ecc_page_hamming (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .stb_i(stb_i), .din_i(din_i),
        .mode_i(mode_i), .bus16_i(bus16_i),
        .par_lo_o(par_lo_o), .par_hi_o(par_hi_o),
        .err_any_o(err_any_o), .err_ecc_o(err_ecc_o), .err_multi_o(err_multi_o),
        .check_done_o(check_done_o)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic int nwords(input int mode, input bit b16);
        return (512 << mode) >> (b16 ? 1 : 0);
    endfunction

    // Parity by definition over every set data bit.
    task automatic model(input int n, input bit b16, output logic [15:0] p, output logic [15:0] pc);
        p  = '0;
        pc = '0;
        for (int w = 0; w < n; w++) begin
            for (int b = 0; b < (b16 ? 16 : 8); b++) begin
                if (pg[w][b]) begin
                    for (int k = 0; k < 16; k++) begin
                        if ((((w << 4) | b) >> k) & 1) p[k] = ~p[k];
                        else pc[k] = ~pc[k];
                    end
                end
            end
        end
    endtask

    task automatic strobe(input logic [15:0] v, input bit gaps);
        @(negedge clk);
        if (gaps && ($urandom % 8 == 0)) begin
            stb_i = 1'b0;
            din_i = 16'($urandom);
            @(negedge clk);
        end
        stb_i = 1'b1;
        din_i = v;
    endtask

    function automatic logic [15:0] lane(input logic [7:0] v, input bit b16);
        return b16 ? {8'h00, v} : {8'($urandom), v};
    endfunction

    task automatic pulse_clear();
        @(negedge clk);
        stb_i = 1'b0;
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        chk("R9 par_lo after clear", 32'(par_lo_o), 32'h0);
        chk("R9 par_hi/done after clear", {15'd0, check_done_o, par_hi_o}, 32'h0);
    endtask

    // kind: 0 clean, 1 single data bit, 2 code bit, 3 two data bits, 4 erased
    task automatic run(input int mode, input bit b16, input int kind, input bit gaps,
                       input bit extra, input bit split_last);
        int n;
        int w1, b1, w2, b2, cb;
        logic [15:0] p, pc, fp, fpc, sp, spc;
        logic [31:0] code;
        logic [15:0] exp_loc;
        logic [2:0]  exp_flags;
        string tag;
        n = nwords(mode, b16);
        mode_i  = 2'(mode);
        bus16_i = b16;
        pulse_clear();
        for (int i = 0; i < n; i++) begin
            pg[i] = (kind == 4) ? 16'hFFFF : 16'($urandom);
            if (!b16) pg[i][15:8] = 8'h00;
        end
        model(n, b16, p, pc);
        code = (kind == 4) ? 32'hFFFF_FFFF : {pc, p};
        w1 = int'($urandom % n);
        b1 = int'($urandom % (b16 ? 16 : 8));
        w2 = (w1 + 1 + int'($urandom % (n - 1))) % n;
        b2 = int'($urandom % (b16 ? 16 : 8));
        cb = int'($urandom % 32);
        exp_loc = 16'h0;
        exp_flags = 3'b000;
        tag = "R5";
        case (kind)
            1: begin
                pg[w1][b1] = ~pg[w1][b1];
                exp_loc = {w1[11:0], b1[3:0]};
                exp_flags = 3'b100;
                tag = "R6";
            end
            2: begin
                code[cb] = ~code[cb];
                exp_flags = 3'b110;
                tag = "R7";
            end
            3: begin
                pg[w1][b1] = ~pg[w1][b1];
                pg[w2][b2] = ~pg[w2][b2];
                exp_loc = 16'hFFFF;
                exp_flags = 3'b101;
                tag = "R8";
            end
            4: begin
                exp_loc = 16'hFFFF;
                exp_flags = 3'b101;
                tag = "R8 erased";
            end
            default: ;
        endcase
        model(n, b16, fp, fpc);
        for (int i = 0; i < n; i++) begin
            strobe(b16 ? pg[i] : lane(pg[i][7:0], 1'b0), gaps);
        end
        @(negedge clk);
        stb_i = 1'b0;
        chk($sformatf("R3 P mode%0d bus16=%0d", mode, b16), 32'(par_lo_o), 32'(fp));
        chk($sformatf("R3 P' mode%0d bus16=%0d", mode, b16), 32'(par_hi_o), 32'(fpc));
        chk("R2 not done after data", 32'(check_done_o), 32'h0);
        sp  = code[15:0];
        spc = code[31:16];
        if (b16) begin
            strobe(sp, gaps);
        end else begin
            strobe(lane(sp[7:0], 1'b0), gaps);
            strobe(lane(sp[15:8], 1'b0), gaps);
            strobe(lane(spc[7:0], 1'b0), gaps);
        end
        if (split_last) begin
            @(negedge clk);
            stb_i = 1'b0;
            chk("R4 done low before last ECC strobe", 32'(check_done_o), 32'h0);
        end
        strobe(b16 ? spc : lane(spc[15:8], 1'b0), 1'b0);
        @(negedge clk);
        stb_i = 1'b0;
        chk({"R4 done after last ECC ", tag}, 32'(check_done_o), 32'h1);
        chk({tag, " flags any/ecc/multi"}, {29'd0, err_any_o, err_ecc_o, err_multi_o},
            {29'd0, exp_flags});
        chk({tag, " location"}, 32'(par_lo_o), 32'(exp_loc));
        if (kind == 1) begin
            chk("R6 correction restores data",
                32'(pg[par_lo_o[15:4]] ^ (16'h1 << par_lo_o[3:0])),
                32'(pg[w1] ^ (16'h1 << b1)));
        end
        if (extra) begin
            for (int i = 0; i < 3; i++) strobe(16'($urandom), 1'b0);
            @(negedge clk);
            stb_i = 1'b0;
            chk("R10 flags after extra strobes",
                {28'd0, check_done_o, err_any_o, err_ecc_o, err_multi_o},
                {28'd0, 1'b1, exp_flags});
            chk("R10 location after extra strobes", 32'(par_lo_o), 32'(exp_loc));
            chk("R10 par_hi after extra strobes", 32'(par_hi_o), 32'(fpc));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (R1..R10 unfinished) actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk("R1 par_lo in reset", 32'(par_lo_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 par_lo/par_hi after reset", {par_lo_o, par_hi_o}, 32'h0);
        chk("R1 flags after reset",
            {28'd0, err_any_o, err_ecc_o, err_multi_o, check_done_o}, 32'h0);

        // Directed corner cases.
        run(0, 1'b0, 0, 1'b0, 1'b1, 1'b1);
        run(0, 1'b1, 0, 1'b1, 1'b0, 1'b1);
        run(0, 1'b0, 4, 1'b0, 1'b1, 1'b0);
        run(1, 1'b1, 4, 1'b0, 1'b0, 1'b0);
        run(3, 1'b0, 1, 1'b0, 1'b1, 1'b0);
        run(3, 1'b1, 1, 1'b0, 1'b0, 1'b1);
        run(0, 1'b1, 2, 1'b0, 1'b1, 1'b0);
        run(0, 1'b0, 3, 1'b1, 1'b0, 1'b0);

        // R9: junk strobes, then a clear asserted together with a strobe.
        mode_i  = 2'd0;
        bus16_i = 1'b0;
        for (int i = 0; i < 5; i++) strobe(16'($urandom), 1'b0);
        @(negedge clk);
        clr_i = 1'b1;
        stb_i = 1'b1;
        din_i = 16'hFFFF;
        @(negedge clk);
        clr_i = 1'b0;
        stb_i = 1'b0;
        chk("R9 clear wins over strobe", {par_lo_o, par_hi_o}, 32'h0);
        run(0, 1'b0, 1, 1'b0, 1'b0, 1'b0);

        // Constrained random mix.
        for (int r = 0; r < 14; r++) begin
            run(int'($urandom % 3), 1'($urandom), int'($urandom % 5),
                1'($urandom), 1'($urandom), 1'($urandom));
        end

        summary();
        $finish;
    end

endmodule